// File: doc/BRIEF.md
# Dual Reload Timer with Interrupts

This peripheral holds two independent down-counters behind a 32-bit word-access register port. Each counter has a divisor (reload value) register, a control register and a readable live count. The control register carries an operation command and a tick-source selector. The counter advances only on clock-enable ticks from the source it has selected. Four tick-enable inputs stand in for the clock sources; clock generation itself sits outside the block.

A running counter moves one step down on each selected tick. A tick that arrives while the count is zero reloads the divisor and reports an expiry, so a divisor of N gives a period of N+1 ticks. Each expiry sets a sticky status bit for its own timer. Software masks these bits and clears them through an acknowledge register. One level-sensitive interrupt line is driven whenever any masked status bit is set.

Bus transfers take one cycle. A write is taken at the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr` and the current register state.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, every count, divisor and control register reads zero, the status and mask registers read zero, and `irq` is low. A control value of zero means load with tick selector 0, so both counters stay halted.
- R2: Byte offsets are as follows. Timer0 uses 0x00 for the divisor, 0x04 for the count and 0x08 for the control. Timer1 uses the same layout at 0x10, 0x14 and 0x18. The mask is at 0x48, the acknowledge at 0x4C, raw status at 0x50 and masked status at 0x54. Divisor and mask read back what was written; the mask keeps bits [1:0] only. Control reads back as {selector[4:2], op[1:0]} with zeros above. Any other offset reads zero, and a write to it changes no register.
- R3: Control bits [1:0] carry the operation. Code 0 copies the divisor into the count and leaves the counter halted. Code 1 halts it. Code 2 makes it run. A control write with code 3 is dropped completely, so the control readback and the count are unchanged.
- R4: Control bits [4:2] pick the tick source. Codes 4, 5, 6 and 7 select `tick_src[0]`, `[1]`, `[2]` and `[3]`. Codes 0 to 3 select no source, and the counter does not move.
- R5: In run mode, each selected tick decrements a nonzero count by one. A selected tick at count zero reloads the divisor and sets status bit 0 for timer0 or bit 1 for timer1.
- R6: A divisor write leaves the current count untouched. The new value is used at the next load command or the next reload.
- R7: While halted, the count holds its value. A later run command resumes from that held value.
- R8: Masked status (0x54) equals raw status AND mask. `irq` is high exactly when a masked bit is set. A mask write changes `irq` from the cycle after that write.
- R9: An acknowledge write clears the raw status bits written as 1 and leaves the others alone. The acknowledge offset reads zero. An expiry in the same cycle as an acknowledge of its bit leaves the bit set.
- R10: Status bits stay set until acknowledged. The two timers never change each other's count or status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_src | input | 4 | Clock-enable ticks of the four selectable sources |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt: any masked status bit set |

## Verification
The bound checker watches timer0's counting on every cycle. It checks that a halted count stays put, that a selected run tick decrements the count or reloads the divisor and raises status, that status bits are sticky unless acknowledged, and that `irq` stays low without a masked bit. Some behaviour depends on register contents and command sequences, and only the directed scenarios show it. That covers the register map and readback, unmapped offsets, dropped illegal commands, source selection across all codes, late divisor writes, the mask-to-irq timing and acknowledge against a simultaneous expiry.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
    localparam int unsigned NUM_SRC = 4;
    localparam int unsigned SEL_W   = 3;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_HOLD = 2'd1,
        OP_RUN  = 2'd2,
        OP_BAD  = 2'd3
    } op_e;
endpackage

// File: rtl/dtt_counter.sv
module dtt_counter
    import dtt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   tick_src,
    input  logic                 div_wr,
    input  logic                 ctrl_wr,
    input  logic [CNT_W-1:0]     div_wdata,
    input  logic [SEL_W+1:0]     ctrl_wdata,
    output logic [CNT_W-1:0]     cnt,
    output logic [CNT_W-1:0]     div,
    output op_e                  op,
    output logic [SEL_W-1:0]     sel,
    output logic                 expire
);
    typedef struct packed {
        logic [CNT_W-1:0] div;
        logic [CNT_W-1:0] cnt;
        op_e              op;
        logic [SEL_W-1:0] sel;
    } tmr_t;

    tmr_t state_d, state_q;
    logic tick;
    op_e  new_op;

    always_comb begin
        state_d = state_q;
        expire  = 1'b0;
        new_op  = op_e'(ctrl_wdata[1:0]);
        tick    = state_q.sel[SEL_W-1] & tick_src[state_q.sel[SEL_W-2:0]];

        if (state_q.op == OP_RUN && tick) begin
            if (state_q.cnt == '0) begin
                state_d.cnt = state_q.div;
                expire      = 1'b1;
            end else begin
                state_d.cnt = state_q.cnt - 1'b1;
            end
        end

        if (div_wr) begin
            state_d.div = div_wdata;
        end

        if (ctrl_wr && new_op != OP_BAD) begin
            state_d.op  = new_op;
            state_d.sel = ctrl_wdata[SEL_W+1:2];
            if (new_op == OP_LOAD) begin
                state_d.cnt = state_q.div;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{div: '0, cnt: '0, op: OP_LOAD, sel: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt = state_q.cnt;
    assign div = state_q.div;
    assign op  = state_q.op;
    assign sel = state_q.sel;
endmodule

// File: rtl/dtt_irq.sv
module dtt_irq #(
    parameter int unsigned NUM_TMR = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TMR-1:0] hit,
    input  logic               mask_wr,
    input  logic               ack_wr,
    input  logic [NUM_TMR-1:0] wbits,
    output logic [NUM_TMR-1:0] status,
    output logic [NUM_TMR-1:0] mask,
    output logic               irq
);
    typedef struct packed {
        logic [NUM_TMR-1:0] status;
        logic [NUM_TMR-1:0] mask;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (ack_wr) begin
            irq_d.status = irq_q.status & ~wbits;
        end
        // an expiry wins over a simultaneous acknowledge
        irq_d.status = irq_d.status | hit;
        if (mask_wr) begin
            irq_d.mask = wbits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign status = irq_q.status;
    assign mask   = irq_q.mask;
    assign irq    = |(irq_q.status & irq_q.mask);
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
    import dtt_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned NUM_TMR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        tick_src,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] OFF_DIV    = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] OFF_CNT    = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] OFF_CTRL   = ADDR_W'(8'h08);
    localparam int unsigned       TMR_STRIDE = 16;
    localparam logic [ADDR_W-1:0] OFF_MASK   = ADDR_W'(8'h48);
    localparam logic [ADDR_W-1:0] OFF_ACK    = ADDR_W'(8'h4C);
    localparam logic [ADDR_W-1:0] OFF_RAW    = ADDR_W'(8'h50);
    localparam logic [ADDR_W-1:0] OFF_MSKD   = ADDR_W'(8'h54);
    localparam int unsigned       CTRL_W     = SEL_W + 2;

    logic [CNT_W-1:0]   cnt_arr [NUM_TMR];
    logic [CNT_W-1:0]   div_arr [NUM_TMR];
    op_e                op_arr  [NUM_TMR];
    logic [SEL_W-1:0]   sel_arr [NUM_TMR];
    logic [NUM_TMR-1:0] hit;
    logic [NUM_TMR-1:0] status;
    logic [NUM_TMR-1:0] mask;

    for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(gi * TMR_STRIDE);
        logic div_wr_s;
        logic ctrl_wr_s;

        assign div_wr_s  = bus_wr && bus_addr == BASE + OFF_DIV;
        assign ctrl_wr_s = bus_wr && bus_addr == BASE + OFF_CTRL;

        dtt_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_src   (tick_src),
            .div_wr     (div_wr_s),
            .ctrl_wr    (ctrl_wr_s),
            .div_wdata  (bus_wdata[CNT_W-1:0]),
            .ctrl_wdata (bus_wdata[CTRL_W-1:0]),
            .cnt        (cnt_arr[gi]),
            .div        (div_arr[gi]),
            .op         (op_arr[gi]),
            .sel        (sel_arr[gi]),
            .expire     (hit[gi])
        );
    end

    dtt_irq #(.NUM_TMR(NUM_TMR)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .mask_wr (bus_wr && bus_addr == OFF_MASK),
        .ack_wr  (bus_wr && bus_addr == OFF_ACK),
        .wbits   (bus_wdata[NUM_TMR-1:0]),
        .status  (status),
        .mask    (mask),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (bus_addr == ADDR_W'(i * TMR_STRIDE) + OFF_DIV) begin
                bus_rdata = DATA_W'(div_arr[i]);
            end
            if (bus_addr == ADDR_W'(i * TMR_STRIDE) + OFF_CNT) begin
                bus_rdata = DATA_W'(cnt_arr[i]);
            end
            if (bus_addr == ADDR_W'(i * TMR_STRIDE) + OFF_CTRL) begin
                bus_rdata = DATA_W'({sel_arr[i], op_arr[i]});
            end
        end
        case (bus_addr)
            OFF_MASK: bus_rdata = DATA_W'(mask);
            OFF_RAW:  bus_rdata = DATA_W'(status);
            OFF_MSKD: bus_rdata = DATA_W'(status & mask);
            default:  ;
        endcase
    end
endmodule

// File: rtl/dtt_checker.sv
module dtt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [1:0]  wbits,
    input logic [3:0]  tick_src,
    input logic [31:0] cnt0,
    input logic [31:0] div0,
    input logic [1:0]  op0,
    input logic [2:0]  sel0,
    input logic [1:0]  status,
    input logic [1:0]  mask,
    input logic        irq
);
    logic       ctrl0_wr;
    logic       tick0;
    logic [1:0] ack_now;

    assign ctrl0_wr = bus_wr && bus_addr == 8'h08;
    assign tick0    = sel0[2] & tick_src[sel0[1:0]];
    assign ack_now  = (bus_wr && bus_addr == 8'h4C) ? wbits : 2'b00;

    AST_HALTED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op0 != 2'd2 && !ctrl0_wr) |=> $stable(cnt0)); // R7

    AST_RUN_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (op0 == 2'd2 && tick0 && cnt0 != 32'd0 && !ctrl0_wr) |=> (cnt0 == $past(cnt0) - 32'd1)); // R5

    AST_RELOAD_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (op0 == 2'd2 && tick0 && cnt0 == 32'd0 && !ctrl0_wr) |=> (cnt0 == $past(div0) && status[0])); // R5

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status) & ~$past(ack_now)) & ~status) == 2'b00)); // R10

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & mask) == 2'b00) |-> !irq); // R8
endmodule

bind dual_tick_timer dtt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wbits    (bus_wdata[1:0]),
    .tick_src (tick_src),
    .cnt0     (cnt_arr[0]),
    .div0     (div_arr[0]),
    .op0      (op_arr[0]),
    .sel0     (sel_arr[0]),
    .status   (status),
    .mask     (mask),
    .irq      (irq)
);

// File: tb/dual_tick_timer_tb.sv
module dual_tick_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tick_src = 4'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_tick_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_src  (tick_src),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick_src = 4'b0;
        bus_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input int src);
        @(negedge clk);
        tick_src[src] = 1'b1;
        @(negedge clk);
        tick_src = 4'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        foreach (v[i]) ;
        rd(8'h00, v); chk("R1 div0", v, 0);
        rd(8'h04, v); chk("R1 cnt0", v, 0);
        rd(8'h08, v); chk("R1 ctrl0", v, 0);
        rd(8'h14, v); chk("R1 cnt1", v, 0);
        rd(8'h48, v); chk("R1 mask", v, 0);
        rd(8'h50, v); chk("R1 status", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        do_reset();
        wr(8'h00, 32'h1234_5678);
        wr(8'h10, 32'h0000_00AB);
        wr(8'h18, 32'h0000_0015);
        wr(8'h48, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R2 div0 readback", v, 32'h1234_5678);
        rd(8'h10, v); chk("R2 div1 readback", v, 32'h0000_00AB);
        rd(8'h18, v); chk("R2 ctrl1 readback", v, 32'h15);
        rd(8'h48, v); chk("R2 mask keeps two bits", v, 32'h3);
        wr(8'h20, 32'hDEAD_BEEF);
        wr(8'h02, 32'h0000_0001);
        rd(8'h20, v); chk("R2 unmapped read", v, 0);
        rd(8'h00, v); chk("R2 unmapped write ignored div0", v, 32'h1234_5678);
        rd(8'h08, v); chk("R2 unmapped write ignored ctrl0", v, 0);
        rd(8'h4C, v); chk("R9 ack reads zero", v, 0);
    endtask

    task automatic t_run_expire();
        logic [31:0] v;
        do_reset();
        wr(8'h00, 3);
        wr(8'h08, 32'h10);
        rd(8'h04, v); chk("R3 load copies divisor", v, 3);
        pulse(0);
        rd(8'h04, v); chk("R3 load leaves halted", v, 3);
        wr(8'h08, 32'h12);
        pulse(0); rd(8'h04, v); chk("R5 dec to 2", v, 2);
        pulse(0); pulse(0);
        rd(8'h04, v); chk("R5 reach 0", v, 0);
        rd(8'h50, v); chk("R5 no status before reload", v, 0);
        pulse(0);
        rd(8'h04, v); chk("R5 reload", v, 3);
        rd(8'h50, v); chk("R5 status bit0", v, 1);
        wr(8'h08, 32'h13);
        rd(8'h08, v); chk("R3 op3 dropped", v, 32'h12);
        pulse(0); rd(8'h04, v); chk("R3 still running after op3", v, 2);
        pulse(1); rd(8'h04, v); chk("R4 other source ignored", v, 2);
        rd(8'h14, v); chk("R10 timer1 untouched", v, 0);
    endtask

    task automatic t_select();
        logic [31:0] v;
        do_reset();
        wr(8'h10, 5);
        wr(8'h18, 32'h1C);
        wr(8'h18, 32'h1E);
        pulse(0); pulse(1); pulse(2);
        rd(8'h14, v); chk("R4 sel7 ignores src0-2", v, 5);
        pulse(3);
        rd(8'h14, v); chk("R4 sel7 uses src3", v, 4);
        for (int code = 0; code < 4; code++) begin
            wr(8'h18, 32'((code << 2) | 2));
            pulse(0); pulse(1); pulse(2); pulse(3);
            rd(8'h14, v); chk("R4 no-source code holds", v, 4);
        end
        wr(8'h18, 32'h16);
        pulse(1);
        rd(8'h14, v); chk("R4 sel5 uses src1", v, 3);
        wr(8'h18, 32'h1A);
        pulse(2);
        rd(8'h14, v); chk("R4 sel6 uses src2", v, 2);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        do_reset();
        wr(8'h00, 9);
        wr(8'h08, 32'h10);
        wr(8'h08, 32'h12);
        pulse(0);
        wr(8'h08, 32'h11);
        pulse(0); pulse(0);
        rd(8'h04, v); chk("R7 hold freezes", v, 8);
        wr(8'h08, 32'h12);
        pulse(0);
        rd(8'h04, v); chk("R7 resume from held", v, 7);
    endtask

    task automatic t_div_late();
        logic [31:0] v;
        do_reset();
        wr(8'h00, 3);
        wr(8'h08, 32'h10);
        wr(8'h08, 32'h12);
        pulse(0);
        wr(8'h00, 7);
        rd(8'h04, v); chk("R6 divisor write keeps count", v, 2);
        pulse(0); pulse(0); pulse(0);
        rd(8'h04, v); chk("R6 reload uses new divisor", v, 7);
        wr(8'h00, 1);
        wr(8'h08, 32'h10);
        rd(8'h04, v); chk("R6 load uses new divisor", v, 1);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        do_reset();
        wr(8'h08, 32'h12);
        pulse(0);
        rd(8'h50, v); chk("R5 zero divisor expires every tick", v, 1);
        rd(8'h54, v); chk("R8 masked zero", v, 0);
        chk("R8 irq low unmasked", {31'b0, irq}, 0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h48; bus_wdata = 32'h1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        chk("R8 irq after mask write", {31'b0, irq}, 1);
        rd(8'h54, v); chk("R8 masked status", v, 1);
        wr(8'h4C, 32'h2);
        rd(8'h50, v); chk("R9 ack other bit keeps", v, 1);
        wr(8'h4C, 32'h1);
        rd(8'h50, v); chk("R9 ack clears", v, 0);
        chk("R9 irq drops", {31'b0, irq}, 0);
        wr(8'h18, 32'h1E);
        pulse(3);
        rd(8'h50, v); chk("R10 timer1 sets bit1", v, 2);
        chk("R8 bit1 masked off", {31'b0, irq}, 0);
        @(negedge clk);
        tick_src[0] = 1'b1;
        bus_wr = 1'b1; bus_addr = 8'h4C; bus_wdata = 32'h1;
        @(negedge clk);
        tick_src = 4'b0; bus_wr = 1'b0;
        rd(8'h50, v); chk("R9 expiry beats ack", v, 3);
        repeat (3) @(negedge clk);
        rd(8'h50, v); chk("R10 sticky", v, 3);
    endtask

    initial begin
        t_reset();
        t_map();
        t_run_expire();
        t_select();
        t_hold();
        t_div_late();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule